// File: doc/BRIEF.md
# AHB-Lite Test Memory with Console and Exit Ports

This block is a zero-wait-state AHB-Lite subordinate for simulation benches and early bring-up. It holds a byte-addressable RAM that starts at address zero. Above the RAM it decodes a small window of test I/O words. A program running on a manager can print a character or a 32-bit value through this window, or end the run with an exit code. Each I/O write becomes a one-cycle strobe with its data at the block's edge, where a bench can watch for it.

Each transfer is captured in its address phase and acted on in the data phase that follows. Reads return the aligned word that holds the address. Writes store 2^HSIZE bytes, starting at the captured address, from the low lanes of the write data. This relies on the manager repeating narrow data on every byte lane. The block never stalls and never signals an error. Only single transfers are handled.

Top module: `tmem_top`

## Requirements
- R1: `hready` is 1 and `hresp` is 0 (OKAY) in every cycle after reset.
- R2: A transfer is started only when `hsel` is 1 and `htrans[1]` is 1 (NONSEQ 2'b10 or SEQ 2'b11). An address phase with IDLE (2'b00), BUSY (2'b01) or `hsel` low causes no write and no strobe.
- R3: Address, direction and size are sampled at the clock edge that ends the address phase. A write takes `hwdata` during the following data phase and stores it at the edge that ends that data phase.
- R4: A write stores N bytes at the captured address and upward: N=1 for HSIZE 0, N=2 for HSIZE 1, and N=4 for HSIZE 2 or more. Byte i comes from `hwdata[8i+7:8i]`.
- R5: In the data phase of a read, `hrdata` holds the four bytes at the captured address with bits [1:0] cleared, in little-endian order (the lowest address in bits [7:0]).
- R6: A read at or above RAM_BYTES returns 0. Write bytes that fall at or above RAM_BYTES are dropped and do not wrap into the RAM.
- R7: A write to IO_BASE (0x8000_0000) pulses `chr_vld` in the cycle after its data phase, with `chr_byte` = `hwdata[7:0]`.
- R8: A write to IO_BASE+4 pulses `val_vld` in the cycle after its data phase, with `val_word` = `hwdata`.
- R9: A write to IO_BASE+8 pulses `ext_vld` in the cycle after its data phase, with `ext_code` = `hwdata`.
- R10: At most one strobe is high in any cycle. A single write gives a one-cycle pulse. Reads of the I/O window, and writes to other addresses in it, give no strobe.
- R11: Reset clears the pending data phase and the strobes. An address phase captured while reset is low writes nothing and gives no strobe.
- R12: When a read's address phase overlaps the data phase of a write to the same word, the read returns the newly written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hsel | input | 1 | Subordinate select |
| haddr | input | 32 | Byte address |
| htrans | input | 2 | Transfer type |
| hwrite | input | 1 | 1 = write |
| hsize | input | 3 | log2 of transfer bytes |
| hwdata | input | 32 | Write data (data phase) |
| hrdata | output | 32 | Read data (data phase) |
| hready | output | 1 | Always 1 |
| hresp | output | 1 | Always 0 (OKAY) |
| chr_vld | output | 1 | Character strobe |
| chr_byte | output | 8 | Character |
| val_vld | output | 1 | Value strobe |
| val_word | output | 32 | Value |
| ext_vld | output | 1 | Exit strobe |
| ext_code | output | 32 | Exit code |

## Verification
Because the bus is pipelined, a write's data phase can share a cycle with the next transfer's address phase. The bench provokes this overlap in two ways. In the first, a word write is followed at once by a read of the same word. The read data seen in the next cycle must be the new value, not the old one. In the second, a RAM write is followed at once by a value-port write. The bench then checks that the RAM holds the first word and that the strobe carries the second word, each in the cycle that R7–R9 set.

// File: rtl/tmem_pkg.sv
// Shared types for the test memory.
// Assumes a 32-bit AHB-Lite address bus.
package tmem_pkg;
    localparam int unsigned AW = 32;

    // Transfer state captured in the address phase
    typedef struct packed {
        logic          active;
        logic          write;
        logic [2:0]    size;
        logic [AW-1:0] addr;
    } dphase_t;

    // Which I/O word a data phase hits
    typedef enum logic [1:0] {
        IOSEL_NONE = 2'd0,
        IOSEL_CHR  = 2'd1,
        IOSEL_VAL  = 2'd2,
        IOSEL_EXT  = 2'd3
    } iosel_e;
endpackage

// File: rtl/tmem_aphase.sv
// Address-phase capture. Since the block never stalls, the bus state is
// sampled at every edge and held for the data phase that follows.
// Assumes hready is always high, so there is no hold path.
module tmem_aphase
    import tmem_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hsel,
    input  logic [1:0]    htrans,
    input  logic          hwrite,
    input  logic [2:0]    hsize,
    input  logic [AW-1:0] haddr,
    output dphase_t       dp
);
    logic req;
    logic unused_trans_lsb;

    // Decide whether this address phase starts a transfer
    assign req              = hsel && htrans[1];
    assign unused_trans_lsb = htrans[0];

    // Capture the transfer for the next data phase; reset leaves it idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dp <= '0;
        end else begin
            dp.active <= req;
            dp.write  <= hwrite;
            dp.size   <= hsize;
            dp.addr   <= haddr;
        end
    end

    AST_DP_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !dp.active); // R11
    AST_NO_DP_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(hsel && htrans[1]) |-> !dp.active); // R2
endmodule

// File: rtl/tmem_ram.sv
// Byte RAM. Writes go in from the low write-data lanes, starting at the
// captured address. Reads return the aligned word, combinationally from
// the captured address.
// Assumes RAM_BYTES is a power of two and a multiple of DW/8.
module tmem_ram
    import tmem_pkg::*;
#(
    parameter int unsigned RAM_BYTES = 1024,
    parameter int unsigned DW        = 32
) (
    input  logic          clk,
    input  dphase_t       dp,
    input  logic [DW-1:0] hwdata,
    output logic [DW-1:0] rdata
);
    localparam int unsigned LANES  = DW / 8;
    localparam int unsigned LANE_W = $clog2(LANES);
    localparam int unsigned RAM_AW = $clog2(RAM_BYTES);
    localparam logic [AW:0] LIMIT  = (AW+1)'(RAM_BYTES);

    logic [7:0]        mem [RAM_BYTES];
    logic [LANE_W:0]   nbytes;
    logic [LANES-1:0]  lane_en;
    logic [RAM_AW-1:0] widx [LANES];
    logic [RAM_AW-1:0] ridx;
    logic              rd_hit;

    // Turn the size code into a byte count, capped at the bus width
    always_comb begin
        if (dp.size >= 3'(LANE_W)) nbytes = (LANE_W+1)'(LANES);
        else                       nbytes = (LANE_W+1)'(1) << dp.size;
    end

    // Per-lane target address and enable, with bytes past the end dropped
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [AW:0] sum;
        assign sum        = {1'b0, dp.addr} + (AW+1)'(i);
        assign widx[i]    = sum[RAM_AW-1:0];
        assign lane_en[i] = dp.active && dp.write &&
                            ((LANE_W+1)'(i) < nbytes) && (sum < LIMIT);
    end

    // Store the enabled write lanes at the end of the data phase
    always_ff @(posedge clk) begin
        for (int i = 0; i < LANES; i++) begin
            if (lane_en[i]) mem[widx[i]] <= hwdata[8*i +: 8];
        end
    end

    // Find the aligned word base and check that it is inside the RAM
    assign ridx   = {dp.addr[RAM_AW-1:LANE_W], {LANE_W{1'b0}}};
    assign rd_hit = dp.active && !dp.write && ({1'b0, dp.addr} < LIMIT);

    // Build the little-endian read word, or 0 outside the RAM
    always_comb begin
        rdata = '0;
        if (rd_hit) begin
            for (int k = 0; k < LANES; k++) begin
                rdata[8*k +: 8] = mem[ridx + RAM_AW'(k)];
            end
        end
    end
endmodule

// File: rtl/tmem_io.sv
// Test I/O window. It decodes data-phase writes to three words at IO_BASE
// and registers a one-cycle strobe with its data for each.
// Assumes the window does not overlap the RAM.
module tmem_io
    import tmem_pkg::*;
#(
    parameter int unsigned DW      = 32,
    parameter logic [31:0] IO_BASE = 32'h8000_0000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dp_active,
    input  logic          dp_write,
    input  logic [AW-1:0] dp_addr,
    input  logic [DW-1:0] hwdata,
    output logic          chr_vld,
    output logic [7:0]    chr_byte,
    output logic          val_vld,
    output logic [DW-1:0] val_word,
    output logic          ext_vld,
    output logic [DW-1:0] ext_code
);
    localparam logic [AW-1:0] A_CHR = AW'(IO_BASE);
    localparam logic [AW-1:0] A_VAL = AW'(IO_BASE) + AW'(4);
    localparam logic [AW-1:0] A_EXT = AW'(IO_BASE) + AW'(8);

    iosel_e sel;

    // Work out which I/O word this data-phase write hits
    always_comb begin
        sel = IOSEL_NONE;
        if (dp_active && dp_write) begin
            unique case (dp_addr)
                A_CHR:   sel = IOSEL_CHR;
                A_VAL:   sel = IOSEL_VAL;
                A_EXT:   sel = IOSEL_EXT;
                default: sel = IOSEL_NONE;
            endcase
        end
    end

    // Register the strobes and hold the last data for each port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chr_vld  <= 1'b0;
            val_vld  <= 1'b0;
            ext_vld  <= 1'b0;
            chr_byte <= '0;
            val_word <= '0;
            ext_code <= '0;
        end else begin
            chr_vld <= (sel == IOSEL_CHR);
            val_vld <= (sel == IOSEL_VAL);
            ext_vld <= (sel == IOSEL_EXT);
            if (sel == IOSEL_CHR) chr_byte <= hwdata[7:0];
            if (sel == IOSEL_VAL) val_word <= hwdata;
            if (sel == IOSEL_EXT) ext_code <= hwdata;
        end
    end

    AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({chr_vld, val_vld, ext_vld})); // R10
    AST_CHR_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        chr_vld |-> $past(dp_active && dp_write && dp_addr == A_CHR)); // R7
    AST_VAL_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        val_vld |-> $past(dp_active && dp_write && dp_addr == A_VAL)); // R8
    AST_EXT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        ext_vld |-> $past(dp_active && dp_write && dp_addr == A_EXT)); // R9
endmodule

// File: rtl/tmem_top.sv
// AHB-Lite test memory: a zero-wait RAM with a console and exit window
// above it. The subordinate is always ready and always answers OKAY.
// Assumes single transfers only; burst types are treated as singles.
module tmem_top
    import tmem_pkg::*;
#(
    parameter int unsigned RAM_BYTES = 1024,
    parameter logic [31:0] IO_BASE   = 32'h8000_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        hsel,
    input  logic [31:0] haddr,
    input  logic [1:0]  htrans,
    input  logic        hwrite,
    input  logic [2:0]  hsize,
    input  logic [31:0] hwdata,
    output logic [31:0] hrdata,
    output logic        hready,
    output logic        hresp,
    output logic        chr_vld,
    output logic [7:0]  chr_byte,
    output logic        val_vld,
    output logic [31:0] val_word,
    output logic        ext_vld,
    output logic [31:0] ext_code
);
    localparam int unsigned DW = 32;

    dphase_t dp;

    // The block never stalls and never reports an error
    assign hready = 1'b1;
    assign hresp  = 1'b0;

    tmem_aphase u_aph (
        .clk    (clk),
        .rst_n  (rst_n),
        .hsel   (hsel),
        .htrans (htrans),
        .hwrite (hwrite),
        .hsize  (hsize),
        .haddr  (haddr),
        .dp     (dp)
    );

    tmem_ram #(.RAM_BYTES(RAM_BYTES), .DW(DW)) u_ram (
        .clk    (clk),
        .dp     (dp),
        .hwdata (hwdata),
        .rdata  (hrdata)
    );

    tmem_io #(.DW(DW), .IO_BASE(IO_BASE)) u_io (
        .clk       (clk),
        .rst_n     (rst_n),
        .dp_active (dp.active),
        .dp_write  (dp.write),
        .dp_addr   (dp.addr),
        .hwdata    (hwdata),
        .chr_vld   (chr_vld),
        .chr_byte  (chr_byte),
        .val_vld   (val_vld),
        .val_word  (val_word),
        .ext_vld   (ext_vld),
        .ext_code  (ext_code)
    );
endmodule

// File: tb/sim_tmem_top.sv
module sim_tmem_top;
    localparam logic [31:0] IOB = 32'h8000_0000;
    localparam int NV = 17;
    // Vector layout: {is_read, addr, size, data (write data or expected read)}
    localparam logic [67:0] VEC [NV] = '{
        {1'b0, 32'h000, 3'd2, 32'h11223344},
        {1'b1, 32'h000, 3'd2, 32'h11223344},
        {1'b1, 32'h002, 3'd2, 32'h11223344},
        {1'b0, 32'h001, 3'd0, 32'h000000EE},
        {1'b1, 32'h000, 3'd2, 32'h1122EE44},
        {1'b0, 32'h004, 3'd2, 32'h00000000},
        {1'b0, 32'h006, 3'd1, 32'h0000BEEF},
        {1'b1, 32'h004, 3'd2, 32'hBEEF0000},
        {1'b0, 32'h3FC, 3'd2, 32'h00000000},
        {1'b0, 32'h3FE, 3'd2, 32'hCAFEF00D},
        {1'b1, 32'h3FC, 3'd2, 32'hF00D0000},
        {1'b1, 32'h400, 3'd2, 32'h00000000},
        {1'b1, IOB,     3'd2, 32'h00000000},
        {1'b0, 32'h008, 3'd3, 32'h01020304},
        {1'b1, 32'h008, 3'd2, 32'h01020304},
        {1'b0, 32'h003, 3'd0, 32'h0000005A},
        {1'b1, 32'h000, 3'd2, 32'h5A22EE44}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hsel = 1'b0;
    logic [31:0] haddr = '0;
    logic [1:0]  htrans = 2'b00;
    logic        hwrite = 1'b0;
    logic [2:0]  hsize = 3'd2;
    logic [31:0] hwdata = '0;
    logic [31:0] hrdata;
    logic        hready, hresp;
    logic        chr_vld, val_vld, ext_vld;
    logic [7:0]  chr_byte;
    logic [31:0] val_word, ext_code;

    int checks = 0;
    int fails  = 0;
    int r1_bad = 0;
    logic [31:0] rdv;
    logic [2:0]  stb;

    always #5 clk = ~clk;

    tmem_top u0 (
        .clk(clk), .rst_n(rst_n), .hsel(hsel), .haddr(haddr), .htrans(htrans),
        .hwrite(hwrite), .hsize(hsize), .hwdata(hwdata), .hrdata(hrdata),
        .hready(hready), .hresp(hresp), .chr_vld(chr_vld), .chr_byte(chr_byte),
        .val_vld(val_vld), .val_word(val_word), .ext_vld(ext_vld), .ext_code(ext_code)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One transfer with idle cycles around it; samples read data in the data
    // phase and the strobes in the cycle after it
    task automatic xfer(input logic rd, input logic [31:0] a, input logic [2:0] sz,
                        input logic [31:0] wd);
        @(negedge clk);
        hsel = 1'b1; htrans = 2'b10; hwrite = !rd; haddr = a; hsize = sz;
        @(negedge clk);
        htrans = 2'b00; hsel = 1'b0; hwdata = wd;
        rdv = hrdata;
        @(negedge clk);
        stb = {ext_vld, val_vld, chr_vld};
    endtask

    // Continuous check of the handshake outputs for R1
    always @(negedge clk) if (rst_n && (hready !== 1'b1 || hresp !== 1'b0)) r1_bad++;

    initial begin
        #2_000_000;
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        chk("R11 strobes in reset", {29'd0, ext_vld, val_vld, chr_vld}, 32'd0);
        chk("R1 hready in reset", {31'd0, hready}, 32'd1);
        rst_n = 1'b1;

        // Table walk: RAM writes and reads (R3 R4 R5 R6)
        for (int i = 0; i < NV; i++) begin
            xfer(VEC[i][67], VEC[i][66:35], VEC[i][34:32], VEC[i][31:0]);
            if (VEC[i][67]) chk($sformatf("R5/R4/R6 vec%0d read", i), rdv, VEC[i][31:0]);
            else            chk($sformatf("R3 vec%0d no strobe", i), {29'd0, stb}, 32'd0);
        end

        // R6: a write at RAM_BYTES does not wrap into address 0
        xfer(1'b0, 32'h400, 3'd2, 32'hFFFFFFFF);
        xfer(1'b1, 32'h000, 3'd2, 32'h0);
        chk("R6 no wrap", rdv, 32'h5A22EE44);

        // R2: BUSY and deselected transfers write nothing
        @(negedge clk); hsel = 1'b1; htrans = 2'b01; hwrite = 1'b1; haddr = 32'h0; hsize = 3'd2;
        @(negedge clk); htrans = 2'b00; hsel = 1'b0; hwdata = 32'h99999999;
        @(negedge clk); hsel = 1'b0; htrans = 2'b10; hwrite = 1'b1; haddr = IOB + 8;
        @(negedge clk); htrans = 2'b00; hwdata = 32'h77;
        @(negedge clk);
        chk("R2 deselected exit no strobe", {31'd0, ext_vld}, 32'd0);
        xfer(1'b1, 32'h000, 3'd2, 32'h0);
        chk("R2 busy no write", rdv, 32'h5A22EE44);

        // R7 R8 R9: I/O strobes and data
        xfer(1'b0, IOB, 3'd0, 32'h00000041);
        chk("R7 chr strobe", {29'd0, stb}, 32'b001);
        chk("R7 chr byte", {24'd0, chr_byte}, 32'h41);
        @(negedge clk);
        chk("R10 chr one cycle", {31'd0, chr_vld}, 32'd0);
        xfer(1'b0, IOB + 4, 3'd2, 32'hDEADBEEF);
        chk("R8 val strobe", {29'd0, stb}, 32'b010);
        chk("R8 val word", val_word, 32'hDEADBEEF);
        xfer(1'b0, IOB + 8, 3'd2, 32'h0000002A);
        chk("R9 ext strobe", {29'd0, stb}, 32'b100);
        chk("R9 ext code", ext_code, 32'h2A);

        // R10: I/O reads and unused window words give no strobe
        xfer(1'b1, IOB + 8, 3'd2, 32'h0);
        chk("R10 read no strobe", {29'd0, stb}, 32'd0);
        xfer(1'b0, IOB + 12, 3'd2, 32'h5);
        chk("R10 unused word no strobe", {29'd0, stb}, 32'd0);

        // R12: write then read the same word back to back
        @(negedge clk); hsel = 1'b1; htrans = 2'b10; hwrite = 1'b1; haddr = 32'h20; hsize = 3'd2;
        @(negedge clk); hwdata = 32'h0BADC0DE; hwrite = 1'b0; haddr = 32'h20;
        @(negedge clk); htrans = 2'b00; hsel = 1'b0;
        chk("R12 overlapped read", hrdata, 32'h0BADC0DE);
        // R12: RAM write overlapped with value-port write
        @(negedge clk); hsel = 1'b1; htrans = 2'b10; hwrite = 1'b1; haddr = 32'h24;
        @(negedge clk); hwdata = 32'h13572468; haddr = IOB + 4;
        @(negedge clk); htrans = 2'b00; hsel = 1'b0; hwdata = 32'hA5A5A5A5;
        @(negedge clk);
        chk("R12 overlapped val strobe", {31'd0, val_vld}, 32'd1);
        chk("R12 overlapped val word", val_word, 32'hA5A5A5A5);
        xfer(1'b1, 32'h24, 3'd2, 32'h0);
        chk("R12 overlapped ram word", rdv, 32'h13572468);

        // R11: address phase captured in reset has no effect
        xfer(1'b0, 32'h10, 3'd2, 32'h12345678);
        @(negedge clk); rst_n = 1'b0; hsel = 1'b1; htrans = 2'b10; hwrite = 1'b1; haddr = 32'h10;
        @(negedge clk); rst_n = 1'b1; htrans = 2'b00; hsel = 1'b0; hwdata = 32'hDEADBEEF;
        @(negedge clk);
        xfer(1'b1, 32'h10, 3'd2, 32'h0);
        chk("R11 no write after reset", rdv, 32'h12345678);
        @(negedge clk); rst_n = 1'b0; hsel = 1'b1; htrans = 2'b10; hwrite = 1'b1; haddr = IOB + 8;
        @(negedge clk); rst_n = 1'b1; htrans = 2'b00; hsel = 1'b0; hwdata = 32'h1;
        @(negedge clk);
        chk("R11 no exit after reset", {31'd0, ext_vld}, 32'd0);

        chk("R1 hready/hresp all cycles", r1_bad, 32'd0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule